// File: doc/BRIEF.md
# Signed Booth-Recoded Wallace-Tree Multiplier

This block multiplies two signed two's-complement operands in one pass of combinational logic and returns the full-width signed product. It does not use a behavioural multiply operator. The multiplier operand is recoded into radix-4 Booth digits, one digit for each bit pair. Each digit picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The selected rows, together with one extra row that holds the increment bits of the negated rows, go into a Wallace tree of 3:2 carry-save compressors. The tree reduces them to two rows, and one carry-propagate adder sums those two rows.

The block accepts a new operand pair on every clock and has no iterative sequencing. With the default settings the product and its valid flag are registered, so a result appears one clock after the operands that produced it. When the valid input is low, the registered product keeps its last value. A parameter removes the output register to give a purely combinational path.

Top module: `booth_wallace_mult`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, the following cycle shows `prod_out` equal to the exact 32-bit two's-complement product of `a_in` and `b_in`, both read as signed 16-bit values.
- R2: `out_valid` equals the value that `in_valid` had at the previous rising edge. After reset the latency is exactly one clock.
- R3: While `rst` is high at a rising edge, `out_valid` and `prod_out` are both cleared to zero at that edge.
- R4: An edge at which `in_valid` is low leaves `prod_out` unchanged.
- R5: The operand pair -32768 × -32768 gives +1073741824 (2^30) exactly, with no overflow into the sign bit.
- R6: Products of the other extreme operands (-32768, -32767, -1, 0, 1, 32767, in every pairing) are exact for all sign combinations.
- R7: A new operand pair is accepted on every clock. Back-to-back valid inputs each produce their own correct product on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| a_in | input | 16 | Multiplicand, signed two's complement |
| b_in | input | 16 | Multiplier (Booth-recoded), signed two's complement |
| prod_out | output | 32 | Signed product |
| out_valid | output | 1 | Product on `prod_out` is valid |

## Verification
The checker assumes that `in_valid` and both operands are known (not X) at every rising edge once reset is released. It also assumes that reset is held for at least one edge before the first operands arrive, because its history-based checks only start after a cycle with `rst` low. The bench drives every input on the falling edge, so all inputs are defined and stable at each rising edge. It holds reset over several edges at start-up. It mixes idle cycles into the operand stream so that the hold rule is exercised while the operands keep changing.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Number of rows left after one level of 3:2 compression.
  function automatic int next_rows(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Number of rows entering level lvl, starting from n0 rows.
  function automatic int rows_at(input int n0, input int lvl);
    int n;
    n = n0;
    for (int k = 0; k < lvl; k++) n = next_rows(n);
    return n;
  endfunction

  // Number of compression levels needed to reach two rows.
  function automatic int tree_levels(input int n0);
    int n;
    int l;
    n = n0;
    l = 0;
    while (n > 2) begin
      n = next_rows(n);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/bwm_booth_rows.sv
module bwm_booth_rows #(
  parameter int A_W  = 16,
  parameter int B_W  = 16,
  parameter int PW   = A_W + B_W,
  parameter int NDIG = B_W / 2
) (
  input  logic [A_W-1:0]           a,
  input  logic [B_W-1:0]           b,
  output logic [NDIG:0][PW-1:0]    rows
);

  logic [B_W:0]  b_ext;
  logic [PW-1:0] inc_row;

  assign b_ext = {b, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [2:0] dig;
    logic       one;
    logic       two;
    logic       neg;
    logic [A_W:0] mag;
    logic [A_W:0] val;

    assign dig = b_ext[2*i+2 : 2*i];

    always_comb begin
      one = dig[0] ^ dig[1];
      two = (dig == 3'b011) || (dig == 3'b100);
      neg = dig[2] && (dig != 3'b111);
      if (two)      mag = {a, 1'b0};
      else if (one) mag = {a[A_W-1], a};
      else          mag = '0;
      val = neg ? ~mag : mag;
    end

    assign rows[i] = {{(PW-A_W-1){val[A_W]}}, val} << (2*i);
    assign inc_row[2*i]   = neg;
    assign inc_row[2*i+1] = 1'b0;
  end

  if (PW > 2*NDIG) begin : g_inc_hi
    assign inc_row[PW-1:2*NDIG] = '0;
  end

  assign rows[NDIG] = inc_row;

endmodule

// File: rtl/bwm_csa.sv
module bwm_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  logic [W-1:0] maj;

  assign sum   = x ^ y ^ z;
  assign maj   = (x & y) | (x & z) | (y & z);
  assign carry = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/bwm_wallace.sv
module bwm_wallace
  import bwm_pkg::*;
#(
  parameter int PW   = 32,
  parameter int NROW = 9
) (
  input  logic [NROW-1:0][PW-1:0] rows_in,
  output logic [PW-1:0]           row_s,
  output logic [PW-1:0]           row_c
);

  localparam int NLVL = tree_levels(NROW);

  logic [NLVL:0][NROW-1:0][PW-1:0] lv;

  assign lv[0] = rows_in;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int NIN  = rows_at(NROW, l);
    localparam int NOUT = rows_at(NROW, l + 1);
    localparam int NG   = NIN / 3;
    localparam int NPAS = NIN % 3;

    for (genvar g = 0; g < NG; g++) begin : g_csa
      bwm_csa #(.W(PW)) u_csa (
        .x     (lv[l][3*g]),
        .y     (lv[l][3*g+1]),
        .z     (lv[l][3*g+2]),
        .sum   (lv[l+1][2*g]),
        .carry (lv[l+1][2*g+1])
      );
    end

    for (genvar r = 0; r < NPAS; r++) begin : g_pass
      assign lv[l+1][2*NG+r] = lv[l][3*NG+r];
    end

    for (genvar r = NOUT; r < NROW; r++) begin : g_zero
      assign lv[l+1][r] = '0;
    end
  end

  assign row_s = lv[NLVL][0];
  assign row_c = lv[NLVL][1];

endmodule

// File: rtl/bwm_cpa.sv
module bwm_cpa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  assign s = x + y;

endmodule

// File: rtl/booth_wallace_mult.sv
module booth_wallace_mult #(
  parameter int A_W     = 16,
  parameter int B_W     = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [A_W-1:0]       a_in,
  input  logic [B_W-1:0]       b_in,
  output logic [A_W+B_W-1:0]   prod_out,
  output logic                 out_valid
);

  localparam int PW   = A_W + B_W;
  localparam int NDIG = B_W / 2;
  localparam int NROW = NDIG + 1;

  logic [NROW-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]           red_s;
  logic [PW-1:0]           red_c;
  logic [PW-1:0]           prod_comb;

  bwm_booth_rows #(.A_W(A_W), .B_W(B_W), .PW(PW), .NDIG(NDIG)) u_rows (
    .a    (a_in),
    .b    (b_in),
    .rows (pp_rows)
  );

  bwm_wallace #(.PW(PW), .NROW(NROW)) u_tree (
    .rows_in (pp_rows),
    .row_s   (red_s),
    .row_c   (red_c)
  );

  bwm_cpa #(.W(PW)) u_cpa (
    .x (red_s),
    .y (red_c),
    .s (prod_comb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_out  <= '0;
        out_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) prod_out <= prod_comb;
      end
    end
  end else begin : g_comb
    assign prod_out  = prod_comb;
    assign out_valid = in_valid;
  end

endmodule

// File: rtl/booth_wallace_mult_chk.sv
module booth_wallace_mult_chk #(
  parameter int A_W     = 16,
  parameter int B_W     = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [A_W-1:0]     a_in,
  input logic [B_W-1:0]     b_in,
  input logic [A_W+B_W-1:0] prod_out,
  input logic               out_valid
);

  localparam int PW = A_W + B_W;

  logic [PW-1:0] ref_prod;
  assign ref_prod = PW'($signed(a_in) * $signed(b_in));

  if (REG_OUT) begin : g_seq
    // R1
    prod_exact_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && !$past(rst)) |-> (prod_out == $past(ref_prod)));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

    // R3
    reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && prod_out == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(in_valid) && !$past(rst)) |-> $stable(prod_out));

    // R5
    min_square_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && !$past(rst) && $past(a_in) == {1'b1, {(A_W-1){1'b0}}}
        && $past(b_in) == {1'b1, {(B_W-1){1'b0}}})
        |-> (prod_out == (PW'(1) << (PW - 2))));
  end

endmodule

bind booth_wallace_mult booth_wallace_mult_chk #(
  .A_W(A_W), .B_W(B_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_in      (a_in),
  .b_in      (b_in),
  .prod_out  (prod_out),
  .out_valid (out_valid)
);

// File: tb/booth_wallace_mult_bench.sv
module booth_wallace_mult_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic [31:0] prod_out;
  logic        out_valid;

  int vectors = 0;
  int errors  = 0;

  logic [31:0] exp_prod  = '0;
  logic        exp_valid = 1'b0;
  bit          done      = 1'b0;

  always #2 clk = ~clk;

  booth_wallace_mult u_booth_wallace_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .prod_out  (prod_out),
    .out_valid (out_valid)
  );

  function automatic logic [31:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
    longint px;
    longint py;
    px = longint'($signed(x));
    py = longint'($signed(y));
    return 32'(px * py);
  endfunction

  task automatic check(input string req);
    vectors++;
    if (out_valid !== exp_valid || prod_out !== exp_prod) begin
      errors++;
      $display("FAIL %s: got valid=%0b prod=%h, expected valid=%0b prod=%h",
               req, out_valid, prod_out, exp_valid, exp_prod);
    end
  endtask

  // Check the result of the previous edge, then drive the next pair.
  task automatic step(input logic v, input logic [15:0] x, input logic [15:0] y,
                      input string req);
    @(negedge clk);
    check(req);
    in_valid = v;
    a_in     = x;
    b_in     = y;
    exp_valid = v;
    if (v) exp_prod = ref_mul(x, y);
  endtask

  initial begin
    logic [15:0] ext [6];
    ext[0] = 16'h8000; ext[1] = 16'h8001; ext[2] = 16'hFFFF;
    ext[3] = 16'h0000; ext[4] = 16'h0001; ext[5] = 16'h7FFF;

    // R3: reset clears outputs even with valid operands applied
    in_valid = 1'b1; a_in = 16'h7FFF; b_in = 16'h7FFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3");
    rst = 1'b0;
    in_valid = 1'b0;

    // R5: most negative squared
    step(1'b1, 16'h8000, 16'h8000, "R3");
    step(1'b0, 16'h1234, 16'h4321, "R5");
    if (prod_out !== 32'h4000_0000) begin
      errors++;
      $display("FAIL R5: got %h expected 40000000", prod_out);
    end
    vectors++;

    // R6: all extreme pairings, back to back (R7)
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        step(1'b1, ext[i], ext[j], "R6");

    // R4: idle cycles with changing operands must hold product
    for (int k = 0; k < 8; k++)
      step(1'b0, 16'($urandom), 16'($urandom), "R4");

    // R1/R7: random operands with random idle gaps
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), "R1");

    // R7: long back-to-back burst of random pairs
    for (int k = 0; k < 500; k++)
      step(1'b1, 16'($urandom), 16'($urandom), "R7");

    step(1'b0, 16'h0, 16'h0, "R1");
    step(1'b0, 16'h0, 16'h0, "R2");
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule